// File: doc/BRIEF.md
# Left-to-Right Modular Exponentiator

This block raises a base to an exponent modulo an odd or even modulus: it returns base^exponent mod modulus for unsigned operands of a parameterised width k. A one-cycle start pulse latches the three operands. An accumulator that begins at 1 then walks the exponent from its top bit down to bit 0.

For every exponent bit that is set, the accumulator is first multiplied by the base. Unless the bit is bit 0, the accumulator is then squared. Every modular product comes from a sequential shift-and-add multiplier that handles one multiplier bit per clock. It keeps each running value reduced with a single conditional subtraction of the modulus, so there is no divider anywhere in the block.

When the last bit is done, the answer is written to a result register that holds its value, and a done pulse is raised for one cycle. The caller must keep the base below the modulus and must use a modulus greater than 1. A start pulse that arrives while a computation is running is dropped.

Top module: `modexp_lr`

## Requirements
- R1: After a synchronous active-low reset, `done_o` is 0 and `result_o` is 0.
- R2: For any modulus N > 1, base A < N and exponent B, the value in `result_o` when `done_o` is high equals A^B mod N.
- R3: With base 73, exponent 5 and modulus 3059, the result is 2588.
- R4: An exponent of 0 gives a result of 1 for any modulus greater than 1.
- R5: `done_o` is high for exactly one cycle per accepted start, and `result_o` changes only in the cycle in which `done_o` is high.
- R6: A start pulse that arrives before the running computation has finished is ignored: its operands are not latched, and it produces no second done pulse.
- R7: Moduli close to 2^k work correctly, because the internal additions carry one extra bit. Every intermediate value and the result stay below the modulus, for example with N = 2^32-1, A = N-1 and B = 2^32-1, where the result is N-1.
- R8: The smallest modulus, N = 2, gives results of 0 or 1 that match A^B mod 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that latches operands and starts a run when idle |
| base_i | input | WIDTH | Base A, must be below the modulus |
| expo_i | input | WIDTH | Exponent B |
| modulus_i | input | WIDTH | Modulus N, must be greater than 1 |
| done_o | output | 1 | One-cycle pulse when `result_o` holds a new value |
| result_o | output | WIDTH | Registered result A^B mod N |

## Verification
The bench builds the block with its default WIDTH of 32. At that width a 64-bit reference model stays exact, and the widest operands are in reach. Moduli just under 2^32 make each doubling and each addition overflow k bits, so a lost carry would corrupt the result. An all-ones 32-bit exponent produces the longest run of 63 products, which is also the window used to show that a stray start pulse is dropped.

// File: rtl/modexp_pkg.sv
// Package: shared types for the modular exponentiator.
// Holds the controller state encoding used by the top module.
package modexp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SCAN      = 3'd1,
        ST_MUL_WAIT  = 3'd2,
        ST_SQR_START = 3'd3,
        ST_SQR_WAIT  = 3'd4,
        ST_FINISH    = 3'd5
    } exp_state_t;

endpackage

// File: rtl/modadd_red.sv
// Module: modadd_red
// Combinational modular adder: s = (a + b) mod n.
// Assumes a < n and b < n, so one conditional subtraction of n is enough.
// The sum is formed one bit wider than the operands so that no carry is lost.
module modadd_red #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] n_i,
    output logic [WIDTH-1:0] s_o
);

    logic [WIDTH:0] sum_w;
    logic [WIDTH:0] red_w;
    logic [WIDTH:0] n_ext_w;

    // Widened sum, the same sum less n, and a selection on the comparison.
    always_comb begin
        n_ext_w = {1'b0, n_i};
        sum_w   = {1'b0, a_i} + {1'b0, b_i};
        red_w   = sum_w - n_ext_w;
        s_o     = (sum_w >= n_ext_w) ? red_w[WIDTH-1:0] : sum_w[WIDTH-1:0];
    end

endmodule

// File: rtl/modmul_sa.sv
// Module: modmul_sa
// Sequential shift-and-add modular multiplier: prod = x * y mod n.
// A go pulse, accepted only while idle, latches the operands.
// One bit of y is consumed per cycle, from LSB to MSB, and done pulses after WIDTH steps.
// Assumes x < n and n > 1.
module modmul_sa #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic [WIDTH-1:0] n_i,
    output logic             done_o,
    output logic [WIDTH-1:0] prod_o
);

    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    logic [WIDTH-1:0] partial_q;
    logic [WIDTH-1:0] addend_q;
    logic [WIDTH-1:0] ybits_q;
    logic [WIDTH-1:0] n_q;
    logic [CNT_W-1:0] step_q;
    logic             run_q;
    logic             done_q;
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] dbl_w;

    // Partial sum plus addend, reduced.
    modadd_red #(.WIDTH(WIDTH)) u_acc (
        .a_i (partial_q),
        .b_i (addend_q),
        .n_i (n_q),
        .s_o (sum_w)
    );

    // Addend doubled, reduced.
    modadd_red #(.WIDTH(WIDTH)) u_dbl (
        .a_i (addend_q),
        .b_i (addend_q),
        .n_i (n_q),
        .s_o (dbl_w)
    );

    // Operand load, per-bit accumulate and double, and the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            partial_q <= '0;
            addend_q  <= '0;
            ybits_q   <= '0;
            n_q       <= '0;
            step_q    <= '0;
            run_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i && !run_q) begin
                partial_q <= '0;
                addend_q  <= x_i;
                ybits_q   <= y_i;
                n_q       <= n_i;
                step_q    <= '0;
                run_q     <= 1'b1;
            end else if (run_q) begin
                if (ybits_q[0]) begin
                    partial_q <= sum_w;
                end
                addend_q <= dbl_w;
                ybits_q  <= ybits_q >> 1;
                step_q   <= step_q + 1'b1;
                if (step_q == LAST_STEP) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign prod_o = partial_q;

endmodule

// File: rtl/modexp_lr.sv
// Module: modexp_lr
// Left-to-right modular exponentiator: result = base^expo mod modulus.
// The accumulator starts at 1. For each exponent bit from MSB to LSB, a set bit
// multiplies the accumulator by the base, and the accumulator is then squared
// unless the bit is bit 0. Starts are ignored while busy.
// Assumes modulus > 1 and base < modulus.
module modexp_lr
    import modexp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] base_i,
    input  logic [WIDTH-1:0] expo_i,
    input  logic [WIDTH-1:0] modulus_i,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);

    localparam int IDX_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

    exp_state_t       state_q;
    logic [WIDTH-1:0] base_q;
    logic [WIDTH-1:0] expo_q;
    logic [WIDTH-1:0] mod_q;
    logic [WIDTH-1:0] acc_q;
    logic [IDX_W-1:0] idx_q;
    logic [WIDTH-1:0] result_q;
    logic             done_q;

    logic             mul_go;
    logic [WIDTH-1:0] mul_x;
    logic             mul_done;
    logic [WIDTH-1:0] mul_prod;
    logic             cur_bit;
    logic             last_bit;
    logic             busy_w;

    // Current exponent bit, last-bit flag, and the multiplier request and operands.
    always_comb begin
        cur_bit  = expo_q[idx_q];
        last_bit = (idx_q == '0);
        busy_w   = (state_q != ST_IDLE);
        mul_go   = ((state_q == ST_SCAN) && cur_bit) || (state_q == ST_SQR_START);
        mul_x    = (state_q == ST_SCAN) ? base_q : acc_q;
    end

    modmul_sa #(.WIDTH(WIDTH)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (mul_go),
        .x_i    (mul_x),
        .y_i    (acc_q),
        .n_i    (mod_q),
        .done_o (mul_done),
        .prod_o (mul_prod)
    );

    // Exponent-scan controller: operand capture, multiply/square sequencing, result update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            base_q   <= '0;
            expo_q   <= '0;
            mod_q    <= '0;
            acc_q    <= '0;
            idx_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= base_i;
                        expo_q  <= expo_i;
                        mod_q   <= modulus_i;
                        acc_q   <= WIDTH'(1);
                        idx_q   <= TOP_IDX;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (cur_bit) begin
                        state_q <= ST_MUL_WAIT;
                    end else if (last_bit) begin
                        state_q <= ST_FINISH;
                    end else begin
                        state_q <= ST_SQR_START;
                    end
                end
                ST_MUL_WAIT: begin
                    if (mul_done) begin
                        acc_q   <= mul_prod;
                        state_q <= last_bit ? ST_FINISH : ST_SQR_START;
                    end
                end
                ST_SQR_START: begin
                    state_q <= ST_SQR_WAIT;
                end
                ST_SQR_WAIT: begin
                    if (mul_done) begin
                        acc_q   <= mul_prod;
                        idx_q   <= idx_q - 1'b1;
                        state_q <= ST_SCAN;
                    end
                end
                ST_FINISH: begin
                    result_q <= acc_q;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign done_o   = done_q;
    assign result_o = result_q;

endmodule

// File: rtl/modexp_lr_chk.sv
// Module: modexp_lr_chk
// Assertion checker bound into modexp_lr. It watches the handshake, the holding
// of the result, the operand capture, and the bound that keeps values below the modulus.
module modexp_lr_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done_o,
    input logic [WIDTH-1:0] result_o,
    input logic             busy_i,
    input logic [WIDTH-1:0] acc_i,
    input logic [WIDTH-1:0] mod_i
);

    AST_DONE_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R5
    AST_DONE_FROM_RUN:   assert property (@(posedge clk) disable iff (!rst_n) done_o |-> $past(busy_i)); // R5
    AST_RESULT_HELD:     assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(result_o)); // R5
    AST_START_IGNORED:   assert property (@(posedge clk) disable iff (!rst_n) (busy_i && start) |=> $stable(mod_i)); // R6
    AST_RESULT_BELOW_N:  assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (result_o < mod_i)); // R7
    AST_ACC_BELOW_N:     assert property (@(posedge clk) disable iff (!rst_n) busy_i |-> (acc_i < mod_i)); // R7

endmodule

bind modexp_lr modexp_lr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done_o   (done_o),
    .result_o (result_o),
    .busy_i   (busy_w),
    .acc_i    (acc_q),
    .mod_i    (mod_q)
);

// File: tb/sim_modexp_lr.sv
// Directed bench for modexp_lr: one task per scenario, each checking its own results.
module sim_modexp_lr;

    localparam int W = 32;
    localparam int RUN_LIMIT = 4000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] base_i = '0;
    logic [W-1:0] expo_i = '0;
    logic [W-1:0] modulus_i = 32'd3;
    logic         done_o;
    logic [W-1:0] result_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    modexp_lr #(.WIDTH(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_i    (base_i),
        .expo_i    (expo_i),
        .modulus_i (modulus_i),
        .done_o    (done_o),
        .result_o  (result_o)
    );

    // Independent right-to-left square-and-multiply reference.
    function automatic logic [W-1:0] ref_pow(input logic [W-1:0] a, input logic [W-1:0] e,
                                             input logic [W-1:0] n);
        logic [63:0] r;
        logic [63:0] b;
        r = 64'd1 % {32'd0, n};
        b = {32'd0, a} % {32'd0, n};
        for (int i = 0; i < W; i++) begin
            if (e[i]) r = (r * b) % {32'd0, n};
            b = (b * b) % {32'd0, n};
        end
        return r[W-1:0];
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic pulse_start(input logic [W-1:0] a, input logic [W-1:0] e, input logic [W-1:0] n);
        @(negedge clk);
        base_i = a; expo_i = e; modulus_i = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag, output logic [W-1:0] res);
        bit seen = 0;
        res = '0;
        for (int c = 0; c < RUN_LIMIT; c++) begin
            @(negedge clk);
            if (done_o) begin
                seen = 1;
                res = result_o;
                break;
            end
        end
        if (!seen) begin
            total++; bad++;
            $display("FAIL %s actual=no_done expected=done", tag);
        end
    endtask

    task automatic run_one(input string tag, input logic [W-1:0] a, input logic [W-1:0] e,
                           input logic [W-1:0] n, input logic [W-1:0] exp_v);
        logic [W-1:0] res;
        pulse_start(a, e, n);
        wait_done(tag, res);
        check(tag, res, exp_v);
    endtask

    task automatic t_reset;
        check("R1 done after reset", {31'd0, done_o}, '0);
        check("R1 result after reset", result_o, '0);
    endtask

    task automatic t_known;
        run_one("R3 73^5 mod 3059", 32'd73, 32'd5, 32'd3059, 32'd2588);
    endtask

    task automatic t_exp_zero;
        run_one("R4 exponent zero", 32'd12345, 32'd0, 32'd1000003, 32'd1);
        run_one("R4 exponent zero N=2", 32'd1, 32'd0, 32'd2, 32'd1);
    endtask

    task automatic t_done_pulse;
        logic [W-1:0] res;
        pulse_start(32'd7, 32'd9, 32'd101);
        wait_done("R5 run", res);
        check("R5 value", res, ref_pow(32'd7, 32'd9, 32'd101));
        @(negedge clk);
        check("R5 done one cycle", {31'd0, done_o}, '0);
        repeat (20) @(negedge clk);
        check("R5 result held", result_o, res);
    endtask

    task automatic t_ignore_start;
        logic [W-1:0] res;
        int extra = 0;
        pulse_start(32'd123456, 32'hFFFF_FFFF, 32'd999983);
        repeat (5) @(negedge clk);
        pulse_start(32'd5, 32'd3, 32'd97);
        wait_done("R6 run", res);
        check("R6 first operands kept", res, ref_pow(32'd123456, 32'hFFFF_FFFF, 32'd999983));
        for (int c = 0; c < RUN_LIMIT; c++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check("R6 no second done", 32'(extra), 32'd0);
        check("R6 result unchanged", result_o, res);
    endtask

    task automatic t_wide;
        run_one("R7 N=2^32-1 A=N-1", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
        run_one("R7 N=2^32-5", 32'hDEAD_BEEF, 32'h8000_0001, 32'hFFFF_FFFB,
                ref_pow(32'hDEAD_BEEF, 32'h8000_0001, 32'hFFFF_FFFB));
        run_one("R7 N top bit set", 32'h7FFF_FFFF, 32'd65537, 32'h8000_0003,
                ref_pow(32'h7FFF_FFFF, 32'd65537, 32'h8000_0003));
    endtask

    task automatic t_mod2;
        run_one("R8 N=2 odd base", 32'd1, 32'd5, 32'd2, 32'd1);
        run_one("R8 N=2 zero base", 32'd0, 32'd3, 32'd2, 32'd0);
    endtask

    task automatic t_random;
        for (int k = 0; k < 12; k++) begin
            logic [W-1:0] n;
            logic [W-1:0] a;
            logic [W-1:0] e;
            n = $urandom();
            if (k < 4) n = n & 32'h0000_FFFF;
            if (n < 2) n = 32'd3;
            a = $urandom() % n;
            e = $urandom();
            run_one("R2 random", a, e, n, ref_pow(a, e, n));
        end
    endtask

    initial begin
        #(20 * 190000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known();
        t_exp_zero();
        t_done_pulse();
        t_ignore_start();
        t_wide();
        t_mod2();
        t_random();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule